// File: doc/BRIEF.md
# IR remote carrier burst timer

This block times the bursts of an infrared remote-control transmitter. Software writes a 10-bit word. Its low nine bits are a burst length and its top bit says whether the burst carries the modulated carrier. The block then counts that length down in steps of eight clocks. While the count is live, `rem` either carries a square carrier at one twelfth or one eighth of the clock rate, or stays low. `sout` mirrors `rem` with inverted sense.

A level-sensitive `done` output tells a waiting processor that the burst has ended. A request to stop the clock is held back until the burst is finished. Two active-low resets are supported. The normal one leaves `sout` high. The low-voltage one leaves `sout` low until the next write or the next normal reset.

Top module: `ir_burst_timer`

## Requirements
- R1: A `load` pulse stores `load_val[8:0]` as the count and `load_val[9]` as the carrier enable (1 = carrier on). `done` is low from the next clock edge onward.
- R2: With `run` held high, `done` stays low for exactly (N+1)*8 clock cycles after loading N, for every N from 0 to 511. It then returns high and stays high.
- R3: A `load` during a live burst restarts the count from the new value. `done` stays low without a gap, and the burst then lasts (new value + 1)*8 cycles from that load.
- R4: While `run` is low, both the count and the eight-clock prescaler hold their values. Each low cycle of `run` lengthens the burst by exactly one cycle.
- R5: `rem` equals the carrier only while a burst is live and its enable bit is 1. `rem` is low when the enable bit is 0 and when idle.
- R6: The carrier is free-running and independent of loads. With `car_sel`=0 its period is 12 clocks, high for 4. With `car_sel`=1 its period is 8 clocks, high for 4.
- R7: Outside the low-voltage state, `sout` is always the inverse of `rem`.
- R8: A `stop_req` pulse is held pending. `stop_grant` goes high for one cycle only while `done` is high, so a request made during a burst is granted in the first idle cycle after it.
- R9: While `rst_n` is low, and after it is released, the timer is cleared: `done`=1, `rem`=0, `sout`=1, and no grant is pending.
- R10: A low on `lvd_rst_n` clears the timer as R9 does but forces `sout` low. It stays low until the next `load` or a normal reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Normal reset, active low, asynchronous |
| lvd_rst_n | input | 1 | Low-voltage reset, active low, asynchronous |
| load | input | 1 | Write strobe for the timer word |
| load_val | input | 10 | Bit 9 carrier enable, bits 8:0 count |
| run | input | 1 | 1 = count, 0 = freeze |
| car_sel | input | 1 | 0 = clock/12 carrier, 1 = clock/8 carrier |
| stop_req | input | 1 | Request to stop the clock |
| rem | output | 1 | Gated carrier output |
| sout | output | 1 | Inverted companion of rem |
| done | output | 1 | High when no burst is live |
| stop_grant | output | 1 | One-cycle grant of a stop request |

## Verification
The bench sweeps burst lengths 0 to 63 and the top values 255 and 511. It catches an off-by-one terminal count, which would shorten every burst by eight cycles, and a zero count that fails to end the burst. It checks that a reload mid-burst leaves no idle cycle on `done`, and that pausing `run` stretches the burst cycle for cycle rather than dropping a tick. It measures both carrier periods and duty cycles, confirms that a stop request is withheld for the whole burst, and checks that the two reset sources leave `sout` at opposite levels.

// File: rtl/ir_burst_timer.sv
module ir_burst_timer #(
  parameter int CNT_W    = 9,
  parameter int TICK_DIV = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 8,
  parameter int CAR_HIGH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvd_rst_n,
  input  logic             load,
  input  logic [CNT_W:0]   load_val,
  input  logic             run,
  input  logic             car_sel,
  input  logic             stop_req,
  output logic             rem,
  output logic             sout,
  output logic             done,
  output logic             stop_grant
);
  localparam int PRE_W = $clog2(TICK_DIV);
  localparam int MAXD  = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CAR_W = $clog2(MAXD);
  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(TICK_DIV - 1);
  localparam logic [CAR_W-1:0] SLOW_LAST = CAR_W'(SLOW_DIV - 1);
  localparam logic [CAR_W-1:0] FAST_LAST = CAR_W'(FAST_DIV - 1);
  localparam logic [CAR_W-1:0] HIGH_LIM  = CAR_W'(CAR_HIGH);

  logic             rst_all;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [CAR_W-1:0] car_cnt;
  logic [CAR_W-1:0] car_last;
  logic             car_en, busy, stop_pend, lvd_flag, tick, carrier;

  assign rst_all  = rst_n & lvd_rst_n;
  assign tick     = run && busy && (pre == PRE_LAST);
  assign car_last = car_sel ? FAST_LAST : SLOW_LAST;
  assign carrier  = car_cnt < HIGH_LIM;

  always_ff @(posedge clk or negedge rst_all) begin
    if (!rst_all) begin
      cnt    <= '0;
      car_en <= 1'b0;
      busy   <= 1'b0;
      pre    <= '0;
    end else if (load) begin
      cnt    <= load_val[CNT_W-1:0];
      car_en <= load_val[CNT_W];
      busy   <= 1'b1;
      pre    <= '0;
    end else if (run && busy) begin
      pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      if (tick) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_all) begin
    if (!rst_all) car_cnt <= '0;
    else          car_cnt <= (car_cnt >= car_last) ? '0 : car_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_all) begin
    if (!rst_all) stop_pend <= 1'b0;
    else          stop_pend <= (stop_pend | stop_req) & ~stop_grant;
  end

  always_ff @(posedge clk or negedge rst_n or negedge lvd_rst_n) begin
    if (!rst_n)          lvd_flag <= 1'b0;
    else if (!lvd_rst_n) lvd_flag <= 1'b1;
    else if (load)       lvd_flag <= 1'b0;
  end

  assign rem        = busy & car_en & carrier;
  assign sout       = ~rem & ~lvd_flag;
  assign done       = ~busy;
  assign stop_grant = stop_pend & ~busy;

  a_r2_ends_at_zero: assert property (@(posedge clk) disable iff (!rst_all)
    (tick && cnt == '0 && !load) |=> done);
  a_r3_reload_no_gap: assert property (@(posedge clk) disable iff (!rst_all)
    (load && !done) |=> !done);
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_all)
    (!run && !load) |=> ($stable(cnt) && $stable(pre)));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_all)
    done |-> !rem);
  a_r8_grant_idle_only: assert property (@(posedge clk) disable iff (!rst_all)
    stop_grant |-> done);
  a_r8_grant_single: assert property (@(posedge clk) disable iff (!rst_all)
    (stop_grant && !stop_req) |=> !stop_grant);
endmodule

// File: tb/ir_burst_timer_tb.sv
module ir_burst_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, lvd_rst_n = 1'b1, load = 1'b0, run = 1'b1;
  logic car_sel = 1'b0, stop_req = 1'b0;
  logic [9:0] load_val = '0;
  logic rem, sout, done, stop_grant;
  int checks = 0, fails = 0;
  bit finished = 0;

  ir_burst_timer dut_i (.clk(clk), .rst_n(rst_n), .lvd_rst_n(lvd_rst_n), .load(load),
    .load_val(load_val), .run(run), .car_sel(car_sel), .stop_req(stop_req),
    .rem(rem), .sout(sout), .done(done), .stop_grant(stop_grant));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [9:0] v);
    @(negedge clk); load = 1'b1; load_val = v;
    @(negedge clk); load = 1'b0;
  endtask

  function automatic int burst_len(input logic [9:0] dummy);
    return 0;
  endfunction

  task automatic measure(output int n);
    n = 0;
    while (!done && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic carrier_check(input bit sel, input int per, input string req);
    bit s[96];
    int ones = 0;
    bit ok = 1;
    car_sel = sel;
    do_load(10'h3FF);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 96; i++) begin s[i] = rem; ok &= (sout == !rem); @(negedge clk); end
    for (int i = 0; i + per < 96; i++) if (s[i] != s[i+per]) ok = 0;
    for (int i = 0; i < per; i++) ones += s[i];
    chk(ok, req, ok, 1);
    chk(ones == 4, req, ones, 4);
    chk(ok, "R7", ok, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    repeat (3) @(negedge clk);
    chk(done == 1 && rem == 0 && sout == 1 && stop_grant == 0, "R9", {done, rem, sout}, 3'b101);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1 && rem == 0 && sout == 1, "R9", {done, rem, sout}, 3'b101);

    ok = 1;
    for (int v = 0; v < 64; v++) begin
      do_load(10'(v));
      if (done) ok = 0;
      measure(n);
      if (n != (v + 1) * 8) begin
        chk(0, "R2", n, (v + 1) * 8); ok = 1;
      end
    end
    chk(ok, "R1", ok, 1);
    do_load(10'd255); measure(n); chk(n == 2048, "R2", n, 2048);
    do_load(10'd511); measure(n); chk(n == 4096, "R2", n, 4096);
    repeat (20) @(negedge clk);
    chk(done == 1, "R2", done, 1);

    do_load(10'd20);
    ok = 1;
    repeat (50) begin if (done) ok = 0; @(negedge clk); end
    do_load(10'd5);
    measure(n);
    chk(ok, "R3", ok, 1);
    chk(n == 48, "R3", n, 48);

    do_load(10'd3);
    repeat (5) @(negedge clk);
    run = 1'b0;
    repeat (10) @(negedge clk);
    run = 1'b1;
    measure(n);
    chk(n + 15 == 42, "R4", n + 15, 42);

    ok = 1;
    do_load(10'd40);
    while (!done) begin if (rem || !sout) ok = 0; @(negedge clk); end
    chk(ok, "R5", ok, 1);
    ok = 1;
    repeat (30) begin if (rem) ok = 0; @(negedge clk); end
    chk(ok, "R5", ok, 1);

    carrier_check(1'b0, 12, "R6");
    carrier_check(1'b1, 8, "R6");
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);

    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    chk(stop_grant == 1, "R8", stop_grant, 1);
    @(negedge clk);
    chk(stop_grant == 0, "R8", stop_grant, 0);
    do_load(10'd2);
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    ok = 1;
    while (!done) begin if (stop_grant) ok = 0; @(negedge clk); end
    chk(ok, "R8", ok, 1);
    chk(stop_grant == 1, "R8", stop_grant, 1);
    @(negedge clk);
    chk(stop_grant == 0, "R8", stop_grant, 0);

    do_load(10'h3FF);
    repeat (5) @(negedge clk);
    lvd_rst_n = 1'b0; @(negedge clk);
    chk(done == 1 && rem == 0 && sout == 0, "R10", {done, rem, sout}, 3'b100);
    lvd_rst_n = 1'b1; repeat (3) @(negedge clk);
    chk(sout == 0, "R10", sout, 0);
    do_load(10'd1);
    chk(sout == 1, "R10", sout, 1);
    measure(n);
    lvd_rst_n = 1'b0; @(negedge clk); lvd_rst_n = 1'b1; @(negedge clk);
    rst_n = 1'b0; @(negedge clk);
    chk(sout == 1 && done == 1, "R9", {sout, done}, 2'b11);
    rst_n = 1'b1; @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule